// File: doc/BRIEF.md
# Memory-Mapped Control Register Bridge

This bridge gives a processor access to a dedicated control-register bus through plain loads and stores on a 32-bit memory-mapped peripheral bus. The register bus holds 1024 registers of 32 bits each, selected by a 10-bit word index. The bridge claims a 4 KB window of the memory map whose base can be moved at run time through an input. Each accepted single-word access becomes exactly one read or one write on the register bus.

The peripheral side uses a request/done handshake. The master raises `bus_req` with its address, direction, size and data. It keeps them steady until `bus_done` pulses for one cycle, and `bus_err` and `bus_rdata` are valid in that same cycle. On the register side the bridge raises a read or write strobe. It keeps the strobe up until the addressed device acknowledges, and it returns the captured read data with the completion. Accesses that are not naturally aligned single 32-bit words are refused with an error and never reach the register bus. A device that never answers is cut off by a cycle limit, which also sets a sticky status output.

Top module: `ctlreg_window_bridge`

## Requirements
- R1: A request whose byte address bits [31:12] equal `win_base` is served. A request outside that window gets no response: `bus_done` stays low and no register-bus strobe is raised for as long as it is held.
- R2: For an accepted write (`bus_we`=1), `crb_wr` is raised with `crb_addr` equal to byte address bits [11:2] and `crb_wdata` equal to `bus_wdata`. The register at that index is the one written.
- R3: For an accepted read (`bus_we`=0), `crb_rd` is raised. The `crb_rdata` value present on the acknowledge cycle is returned on `bus_rdata`, together with `bus_done`=1 and `bus_err`=0.
- R4: A strobe stays high, with address and write data held, until `crb_ack` is seen. It falls on the next clock edge, and `bus_done` pulses in the cycle after that edge. The strobe is then low for at least one cycle before any new access.
- R5: A request in the window with address bits [1:0] not 00, with `bus_size` not 2'b10 (2'b10 means a 32-bit word), or with `bus_burst`=1 ends with `bus_done`=1 and `bus_err`=1 in the cycle after it is seen. No register-bus strobe is raised for it.
- R6: If no acknowledge arrives, the strobe is held for exactly 64 cycles. The access then ends with `bus_err`=1, the strobe drops, and `tmo_flag` is set.
- R7: After reset, `crb_rd`, `crb_wr`, `bus_done`, `bus_err` and `tmo_flag` are all low.
- R8: `tmo_flag` stays set through later successful accesses until reset.
- R9: A change of `win_base` moves the window. Addresses in the old window are then ignored, and addresses in the new window are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_base | input | 20 | Window base, byte address bits [31:12] |
| bus_req | input | 1 | Peripheral-bus request, held until done |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | Transfer size, 2'b10 = 32-bit word |
| bus_burst | input | 1 | Multi-word request marker |
| bus_wdata | input | 32 | Write data |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error response, valid with done |
| bus_rdata | output | 32 | Read data, valid with done |
| crb_addr | output | 10 | Register word index |
| crb_wdata | output | 32 | Register write data |
| crb_rdata | input | 32 | Register read data |
| crb_rd | output | 1 | Read strobe |
| crb_wr | output | 1 | Write strobe |
| crb_ack | input | 1 | Acknowledge from register device |
| tmo_flag | output | 1 | Sticky timeout status |

## Verification
The hardest case to reach from the ports is the timeout, together with its lasting effect. The bench's register-device model takes a programmable acknowledge delay. Setting that delay beyond the 64-cycle limit forces the cut-off, and the model measures how many edges the strobe was held. The bench then sets a normal delay and runs a write and a read-back to the same index. This shows that the flag persists and that the abandoned access left no trace in the register.

// File: rtl/ctlreg_window_bridge.sv
module ctlreg_window_bridge #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RAW = 10,
  parameter int TMO = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:RAW+2] win_base,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_burst,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_done,
  output logic              bus_err,
  output logic [DW-1:0]     bus_rdata,
  output logic [RAW-1:0]    crb_addr,
  output logic [DW-1:0]     crb_wdata,
  input  logic [DW-1:0]     crb_rdata,
  output logic              crb_rd,
  output logic              crb_wr,
  input  logic              crb_ack,
  output logic              tmo_flag
);
  localparam int WB = RAW + 2;
  localparam int CW = (TMO > 1) ? $clog2(TMO) : 1;
  localparam logic [CW-1:0] CLAST = CW'(TMO - 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  logic hit, bad, strobe;
  assign hit    = bus_addr[AW-1:WB] == win_base;
  assign bad    = (bus_addr[1:0] != 2'b00) || (bus_size != 2'b10) || bus_burst;
  assign strobe = crb_rd | crb_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0;
      bus_done <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
      crb_addr <= '0; crb_wdata <= '0; crb_rd <= 1'b0; crb_wr <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (bus_req && hit) begin
            if (bad) begin
              st <= S_DONE; bus_done <= 1'b1; bus_err <= 1'b1; bus_rdata <= '0;
            end else begin
              st <= S_BUSY; cnt <= '0;
              crb_addr  <= bus_addr[WB-1:2];
              crb_wdata <= bus_wdata;
              crb_rd    <= !bus_we;
              crb_wr    <= bus_we;
            end
          end
        S_BUSY:
          if (crb_ack) begin
            st <= S_DONE; crb_rd <= 1'b0; crb_wr <= 1'b0;
            bus_done <= 1'b1; bus_err <= 1'b0;
            bus_rdata <= crb_rd ? crb_rdata : '0;
          end else if (cnt == CLAST) begin
            st <= S_DONE; crb_rd <= 1'b0; crb_wr <= 1'b0;
            bus_done <= 1'b1; bus_err <= 1'b1; bus_rdata <= '0;
            tmo_flag <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: begin
          st <= S_IDLE; bus_done <= 1'b0; bus_err <= 1'b0;
        end
      endcase
    end
  end

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(crb_rd && crb_wr));
  a_r1_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && bus_req && !hit) |=> (!strobe && !bus_done));
  a_r5_reject_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && bus_req && hit && bad) |=> (!strobe && bus_done && bus_err));
  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !crb_ack && st == S_BUSY && cnt != CLAST) |=>
      (strobe && $stable(crb_addr) && $stable(crb_wdata)));
  a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && crb_ack) |=> (!strobe && bus_done && !bus_err));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> (!bus_done && !strobe));
  a_r6_timeout_end: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !crb_ack && cnt == CLAST) |=> (!strobe && bus_err && tmo_flag));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |=> tmo_flag);
endmodule

// File: tb/tb_ctlreg_window_bridge.sv
`timescale 1ns/1ps
module tb_ctlreg_window_bridge;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [31:12] win_base;
  logic bus_req, bus_we, bus_burst;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0] bus_size;
  logic bus_done, bus_err, crb_rd, crb_wr, tmo_flag;
  logic [31:0] bus_rdata, crb_wdata, crb_rdata;
  logic [9:0] crb_addr;
  logic crb_ack;

  ctlreg_window_bridge dut (.clk, .rst_n, .win_base, .bus_req, .bus_we, .bus_addr,
    .bus_size, .bus_burst, .bus_wdata, .bus_done, .bus_err, .bus_rdata, .crb_addr,
    .crb_wdata, .crb_rdata, .crb_rd, .crb_wr, .crb_ack, .tmo_flag);

  int checks = 0, fails = 0, cycles = 0;
  int ack_delay = 2, hold = 0, last_len = 0, starts = 0;
  logic [9:0] last_idx;
  logic [31:0] regs [1024];

  always @(posedge clk) begin
    if (!rst_n) begin
      crb_ack <= 0; crb_rdata <= 0; hold <= 0; last_len <= 0; last_idx <= 0;
      for (int i = 0; i < 1024; i++) regs[i] <= 32'h5A00_0000 | i;
    end else begin
      crb_ack <= 0;
      if (crb_rd || crb_wr) begin
        if (hold == 0) starts <= starts + 1;
        hold <= hold + 1;
        if (hold + 1 == ack_delay && !crb_ack) begin
          crb_ack <= 1; last_idx <= crb_addr;
          if (crb_wr) regs[crb_addr] <= crb_wdata; else crb_rdata <= regs[crb_addr];
        end
      end else if (hold != 0) begin
        last_len <= hold; hold <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic access(input logic [31:0] a, input bit we, input logic [1:0] sz, input bit bu,
                        input logic [31:0] wd, input int lim,
                        output bit got, output bit err, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1; bus_addr = a; bus_we = we; bus_size = sz; bus_burst = bu; bus_wdata = wd;
    got = 0; err = 0; rd = 0;
    for (int i = 0; i < lim && !got; i++) begin
      @(posedge clk); #1;
      if (bus_done) begin got = 1; err = bus_err; rd = bus_rdata; end
    end
    @(negedge clk); bus_req = 0;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic t_reset();
    #1;
    chk(!crb_rd && !crb_wr && !bus_done && !bus_err && !tmo_flag, "R7 reset outputs",
        {27'd0, crb_rd, crb_wr, bus_done, bus_err, tmo_flag}, 0);
  endtask

  task automatic t_write_read();
    bit g, e; logic [31:0] r; int s0;
    ack_delay = 2;
    access({win_base, 12'h1A8}, 1, 2'b10, 0, 32'hCAFE_0101, 100, g, e, r);
    chk(g && !e, "R2 write completes", {30'd0, g, e}, 32'd2);
    chk(last_idx == 10'h06A, "R2 word index from [11:2]", {22'd0, last_idx}, 32'h6A);
    chk(regs[10'h06A] == 32'hCAFE_0101, "R2 write data", regs[10'h06A], 32'hCAFE_0101);
    s0 = starts;
    access({win_base, 12'h1A8}, 0, 2'b10, 0, 0, 100, g, e, r);
    chk(g && !e && r == 32'hCAFE_0101, "R3 read returns data", r, 32'hCAFE_0101);
    chk(starts == s0 + 1, "R3 one strobe per access", starts, s0 + 1);
    access({win_base, 12'hFFC}, 0, 2'b10, 0, 0, 100, g, e, r);
    chk(r == 32'h5A00_03FF && last_idx == 10'h3FF, "R3 top register", r, 32'h5A00_03FF);
  endtask

  task automatic t_latency();
    bit g, e; logic [31:0] r;
    ack_delay = 5;
    access({win_base, 12'h010}, 0, 2'b10, 0, 0, 100, g, e, r);
    chk(last_len == 6, "R4 strobe held until ack then dropped", last_len, 6);
    chk(r == 32'h5A00_0004 && !e, "R3 delayed read data", r, 32'h5A00_0004);
    ack_delay = 1;
    access({win_base, 12'h014}, 0, 2'b10, 0, 0, 100, g, e, r);
    chk(last_len == 2, "R4 fast ack strobe length", last_len, 2);
  endtask

  task automatic t_reject();
    bit g, e; logic [31:0] r; int s0;
    ack_delay = 2; s0 = starts;
    access({win_base, 12'h022}, 1, 2'b10, 0, 32'h1111_1111, 100, g, e, r);
    chk(g && e, "R5 misaligned error", {30'd0, g, e}, 3);
    access({win_base, 12'h020}, 1, 2'b01, 0, 32'h2222_2222, 100, g, e, r);
    chk(g && e, "R5 halfword error", {30'd0, g, e}, 3);
    access({win_base, 12'h020}, 0, 2'b10, 1, 0, 100, g, e, r);
    chk(g && e, "R5 burst error", {30'd0, g, e}, 3);
    chk(starts == s0 && regs[8] == 32'h5A00_0008, "R5 no register cycle", starts, s0);
  endtask

  task automatic t_outside();
    bit g, e; logic [31:0] r; int s0;
    s0 = starts;
    access({win_base + 20'd1, 12'h000}, 1, 2'b10, 0, 32'h3333_3333, 20, g, e, r);
    chk(!g && starts == s0, "R1 outside window ignored", {31'd0, g}, 0);
  endtask

  task automatic t_timeout();
    bit g, e; logic [31:0] r;
    ack_delay = 1000;
    access({win_base, 12'h040}, 1, 2'b10, 0, 32'hDEAD_BEEF, 200, g, e, r);
    chk(g && e, "R6 timeout error", {30'd0, g, e}, 3);
    chk(last_len == 64, "R6 strobe held 64 cycles", last_len, 64);
    chk(tmo_flag, "R6 timeout flag set", {31'd0, tmo_flag}, 1);
    ack_delay = 2;
    access({win_base, 12'h044}, 1, 2'b10, 0, 32'h0BAD_F00D, 100, g, e, r);
    access({win_base, 12'h040}, 0, 2'b10, 0, 0, 100, g, e, r);
    chk(!e && r == 32'h5A00_0010, "R6 abandoned write left no trace", r, 32'h5A00_0010);
    chk(tmo_flag, "R8 flag sticky after success", {31'd0, tmo_flag}, 1);
  endtask

  task automatic t_move();
    bit g, e; logic [31:0] r; logic [31:12] old;
    old = win_base;
    @(negedge clk); win_base = 20'h8_0012;
    access({old, 12'h044}, 0, 2'b10, 0, 0, 20, g, e, r);
    chk(!g, "R9 old window ignored", {31'd0, g}, 0);
    access({20'h8_0012, 12'h044}, 0, 2'b10, 0, 0, 100, g, e, r);
    chk(g && r == 32'h0BAD_F00D, "R9 new window served", r, 32'h0BAD_F00D);
  endtask

  initial begin
    win_base = 20'hFFFE_0; bus_req = 0; bus_we = 0; bus_addr = 0;
    bus_size = 2'b10; bus_burst = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_write_read();
    t_latency();
    t_reject();
    t_outside();
    t_timeout();
    t_move();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule